// File: doc/BRIEF.md
# Condition Register Predicate Selector

This block sits next to the condition register file, on the side of the file that faces the function units. It receives one read that returns all eight 4-bit condition registers together as a 32-bit word. From that word it picks one bit position out of each register and packs the picks into an 8-bit predicate mask. Only these 8 bits go out on the broadcast bus, so the bus does not have to carry all 32 bits to every function unit that supports predication.

A 2-bit select chooses which bit position is taken, and the same position is used for every register. An invert control complements the selected bits, which gives the "condition false" form of the predicate. When predication is turned off, the mask is forced to all ones, so the ALUs behind the bus run every lane without needing a special case. The result is registered. The output valid strobe follows the input valid by one cycle, and the mask keeps its value between requests.

Top module: `cr_pred_select`

## Requirements
- R1: While the active-low synchronous reset `rst_n` is low, `out_valid` is 0 and `pred_mask` is 8'hFF. Both values hold on the first cycle after reset is released.
- R2: `out_valid` equals the value that `in_valid` had on the previous clock edge.
- R3: Condition register n occupies bits [4n+3:4n] of `cr_word`. The LSB of each field is position 0.
- R4: With `pred_en`=1 and `invert`=0, a request sets `pred_mask[n]` on the next cycle to `cr_word[4n + bit_sel]`. The value 0 on `bit_sel` selects the LSB of each field, and 3 selects the MSB.
- R5: With `pred_en`=1 and `invert`=1, a request sets `pred_mask[n]` to the complement of the bit that R4 would select.
- R6: With `pred_en`=0, a request sets `pred_mask` to 8'hFF whatever the values of `cr_word`, `bit_sel` and `invert`.
- R7: In any cycle where `in_valid` is 0, `pred_mask` keeps its previous value. Its inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; the inputs below are sampled when it is high |
| cr_word | input | 32 | All eight condition registers, CR n in bits [4n+3:4n] |
| bit_sel | input | 2 | Bit position taken from every register |
| invert | input | 1 | Complement the selected bits |
| pred_en | input | 1 | Predication enable; 0 forces an all-ones mask |
| out_valid | output | 1 | Mask update strobe, one cycle after `in_valid` |
| pred_mask | output | 8 | Registered predicate, bit n taken from register n |

## Verification
The bench builds the block with its default parameters: eight registers of four bits each. With these values every bit position of every register can be reached through the 32-bit word. The vectors are chosen so that each select value produces a distinct mask, and a one-hot pattern in the registers shows that the fields sit in the right places. Further tests cover forcing all ones under every combination of invert and enable, holding the mask while `in_valid` is low, and a reset applied in the middle of a run.

// File: rtl/cr_pred_select.sv
module cr_pred_select #(
  parameter int NUM_REGS = 8,
  parameter int FIELD_W  = 4,
  localparam int SEL_W   = $clog2(FIELD_W),
  localparam int WORD_W  = NUM_REGS * FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] cr_word,
  input  logic [SEL_W-1:0]  bit_sel,
  input  logic              invert,
  input  logic              pred_en,
  output logic              out_valid,
  output logic [NUM_REGS-1:0] pred_mask
);

  logic [NUM_REGS-1:0] picked;

  for (genvar n = 0; n < NUM_REGS; n++) begin : g_pick
    logic [FIELD_W-1:0] field;
    assign field     = cr_word[n*FIELD_W +: FIELD_W];
    assign picked[n] = field[bit_sel];
  end

  logic [NUM_REGS-1:0] next_mask;
  assign next_mask = pred_en ? (picked ^ {NUM_REGS{invert}}) : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      pred_mask <= '1;
    end else begin
      out_valid <= in_valid;
      if (in_valid) pred_mask <= next_mask;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && (&pred_mask)));

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));

  assert_lane0_pick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred_en) |=> (pred_mask[0] == ($past(cr_word[bit_sel]) ^ $past(invert))));

  assert_unpred_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pred_en) |=> (&pred_mask));

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(pred_mask));

endmodule

// File: tb/cr_pred_select_test.sv
module cr_pred_select_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] cr_word;
  logic [1:0]  bit_sel;
  logic        invert;
  logic        pred_en;
  logic        out_valid;
  logic [7:0]  pred_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cr_pred_select uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cr_word(cr_word),
    .bit_sel(bit_sel), .invert(invert), .pred_en(pred_en),
    .out_valid(out_valid), .pred_mask(pred_mask)
  );

  // {word, sel, invert, enable, expected mask}
  localparam int NV = 14;
  localparam logic [43:0] VEC [NV] = '{
    {32'h8421F0A5, 2'd0, 1'b0, 1'b1, 8'h19},
    {32'h8421F0A5, 2'd1, 1'b0, 1'b1, 8'h2A},
    {32'h8421F0A5, 2'd2, 1'b0, 1'b1, 8'h49},
    {32'h8421F0A5, 2'd3, 1'b0, 1'b1, 8'h8A},
    {32'h8421F0A5, 2'd2, 1'b1, 1'b1, 8'hB6},
    {32'h8421F0A5, 2'd0, 1'b1, 1'b1, 8'hE6},
    {32'h8421F0A5, 2'd1, 1'b0, 1'b0, 8'hFF},
    {32'h00000000, 2'd0, 1'b1, 1'b0, 8'hFF},
    {32'hFFFFFFFF, 2'd3, 1'b0, 1'b1, 8'hFF},
    {32'hFFFFFFFF, 2'd3, 1'b1, 1'b1, 8'h00},
    {32'h00000000, 2'd0, 1'b0, 1'b1, 8'h00},
    {32'h12481248, 2'd3, 1'b0, 1'b1, 8'h11},
    {32'h12481248, 2'd0, 1'b0, 1'b1, 8'h88},
    {32'h12481248, 2'd1, 1'b1, 1'b1, 8'hBB}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; cr_word = '0; bit_sel = '0; invert = 1'b0; pred_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {7'b0, out_valid}, 8'h00);
    check("R1 mask in reset", pred_mask, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after release", {7'b0, out_valid}, 8'h00);
    check("R1 mask after release", pred_mask, 8'hFF);

    // R3 R4 R5 R6: vector walk
    for (int i = 0; i < NV; i++) begin
      {cr_word, bit_sel, invert, pred_en} = VEC[i][43:8];
      in_valid = 1'b1;
      @(negedge clk);
      check("R2 out_valid after request", {7'b0, out_valid}, 8'h01);
      check($sformatf("R4/R5/R6 vector %0d", i), pred_mask, VEC[i][7:0]);
    end

    // R3: one-hot bit walk over the whole word
    for (int b = 0; b < 32; b++) begin
      cr_word = 32'h1 << b; bit_sel = 2'(b % 4); invert = 1'b0; pred_en = 1'b1; in_valid = 1'b1;
      @(negedge clk);
      check("R3 field placement", pred_mask, 8'h1 << (b / 4));
    end

    // R7: load known mask, then idle with changing inputs
    cr_word = 32'h8421F0A5; bit_sel = 2'd1; invert = 1'b0; pred_en = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R4 load before idle", pred_mask, 8'h2A);
    in_valid = 1'b0; cr_word = 32'hFFFFFFFF; bit_sel = 2'd3; pred_en = 1'b0;
    @(negedge clk);
    check("R2 out_valid drops", {7'b0, out_valid}, 8'h00);
    check("R7 mask held", pred_mask, 8'h2A);
    invert = 1'b1; pred_en = 1'b1; cr_word = 32'h0;
    @(negedge clk);
    check("R7 mask still held", pred_mask, 8'h2A);

    // R1: reset mid-run
    cr_word = 32'h0; bit_sel = 2'd0; invert = 1'b0; pred_en = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R4 zero mask", pred_mask, 8'h00);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mask after mid-run reset", pred_mask, 8'hFF);
    check("R1 out_valid after mid-run reset", {7'b0, out_valid}, 8'h00);
    rst_n = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    check("R1 mask after second release", pred_mask, 8'hFF);

    done = 1'b1;
    finish_run();
  end
endmodule